// File: doc/BRIEF.md
# Serial Configuration Switch Target

This block is a two-wire serial bus target that holds a single 5-bit configuration word, standing in for a small non-volatile store whose value feeds an output stage elsewhere on the chip. A bus controller addresses the target at a fixed 7-bit address. It then moves exactly one data byte, either into the word or out of it. The bus lines arrive as oversampled inputs on the system clock. The target drives the data line only through an open-drain pull-down enable.

Writes are filtered. A write-protect input blocks every update. A data byte with any of its three top bits set is refused. A refused data byte is still acknowledged, so the controller cannot tell a refused byte from an accepted one by the acknowledge alone. Once a write is accepted, the target models a programming interval of a parameterised number of clock cycles. The word takes its new value at the start of that interval. While the interval runs, the target does not answer its own address.

Top module: `cfg_switch_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 1001110 (MSB first; bit 0 is R/W, where 0 means write and 1 means read). For any other address it keeps `sda_oe` at 0 until the next START.
- R2: A write whose data byte has bits 7:5 equal to 0, sent while `wp_i` is 0, loads data bits 4:0 into `cfg_o`. Bit 4 is the unmultiplexed bit and bits 3:0 are the multiplexed bits. The data byte is acknowledged.
- R3: While `wp_i` is 1, `cfg_o` never changes. A data byte written in this state is still acknowledged.
- R4: A write data byte with any of bits 7:5 set is refused and leaves `cfg_o` unchanged. The byte is still acknowledged.
- R5: A read returns the byte {000, stored word}, most significant bit first. A NACK from the controller ends the transfer.
- R6: After reset, `cfg_o` is 00000 and `sda_oe` is 0.
- R7: After an accepted write, the target does not acknowledge its address for PROG_CYCLES clock cycles. After that interval it acknowledges its address again.
- R8: A STOP or a repeated START during a transfer returns the target to idle. A data byte cut short this way leaves `cfg_o` unchanged.
- R9: A refused write, whether blocked by protection or by a malformed byte, starts no programming interval. An address sent at once after it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| wp_i | input | 1 | 1 blocks all writes to the stored word |
| cfg_o | output | 5 | Stored configuration word to the output stage |

## Verification
Two functions can meet in time: the programming interval that follows an accepted write, and the address decision of the next transaction. The bench sends an address straight after an accepted write, so the decision falls inside the interval, and expects a NACK. It sends the same address again once the interval has safely run out and expects an ACK. A refused write followed at once by an address shows that no interval was started. The acknowledge bit on the wire is the verdict in each case, and the bench compares it with what its own model predicts from the write's protection state and byte value.

// File: rtl/cfgsw_pkg.sv
// Package: shared constants and the bus engine state type.
// Assumes: one data byte per transaction, MSB first on the wire.
package cfgsw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } eng_state_t;
endpackage

// File: rtl/cfgsw_sync.sv
// Module: brings the two bus lines into the clock domain with a two-flop
// synchroniser each, then derives edges of the clock line and the START and
// STOP conditions (a data edge while the clock line is high).
// Assumes: the bus is much slower than clk.
module cfgsw_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic             scl_s,
    output logic             sda_s,
    output logic             scl_rise,
    output logic             scl_fall,
    output logic             start_det,
    output logic             stop_det
);
    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] prev_q;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            // Purpose: two-flop synchroniser plus one history flop per line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[g] <= 1'b1;
                    sync_q[g] <= 1'b1;
                    prev_q[g] <= 1'b1;
                end else begin
                    meta_q[g] <= raw_i[g];
                    sync_q[g] <= meta_q[g];
                    prev_q[g] <= sync_q[g];
                end
            end
        end
    endgenerate

    // Purpose: edge and bus-condition decode (line 0 = clock, line 1 = data).
    always_comb begin
        scl_s     = sync_q[0];
        sda_s     = sync_q[1];
        scl_rise  = sync_q[0] && !prev_q[0];
        scl_fall  = !sync_q[0] && prev_q[0];
        start_det = sync_q[0] && prev_q[0] && prev_q[1] && !sync_q[1];
        stop_det  = sync_q[0] && prev_q[0] && !prev_q[1] && sync_q[1];
    end

    a_r8_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det, scl_rise, scl_fall}));
endmodule

// File: rtl/cfgsw_engine.sv
// Module: bus protocol engine. It decodes the address byte, acknowledges
// when it matches and no programming interval runs, then shifts one data
// byte in (write) or out (read). It raises a one-cycle write request with
// the received byte; the store decides whether to take it.
// Assumes: synchronised line levels and edge strobes from cfgsw_sync.
module cfgsw_engine
    import cfgsw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001110,
    parameter int         REG_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy_i,
    input  logic [REG_W-1:0]  word_i,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_oe
);
    localparam int PAD_W = BYTE_W - REG_W;

    eng_state_t        st_q;
    logic [3:0]        bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              rw_q;
    logic              nack_q;
    logic [BYTE_W-1:0] rd_load;

    // Purpose: read byte image, upper bits forced to zero.
    always_comb rd_load = {{PAD_W{1'b0}}, word_i};

    // Purpose: protocol state machine, one step per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            wr_req    <= 1'b0;
        end else begin
            wr_req <= 1'b0;
            if (stop_det) begin
                st_q <= ST_IDLE;
            end else if (start_det) begin
                st_q      <= ST_ADDR;
                bit_cnt_q <= '0;
            end else begin
                case (st_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall && bit_cnt_q == 4'd8) begin
                            if (shreg_q[7:1] == DEV_ADDR && !busy_i) begin
                                rw_q <= shreg_q[0];
                                st_q <= ST_ADDR_ACK;
                            end else begin
                                st_q <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                st_q    <= ST_RDATA;
                                shreg_q <= rd_load;
                            end else begin
                                st_q <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall && bit_cnt_q == 4'd8) begin
                            st_q   <= ST_WDATA_ACK;
                            wr_req <= 1'b1;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) st_q <= ST_IGNORE;
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt_q == 4'd8) st_q <= ST_RACK;
                            else shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                        end else if (scl_fall) begin
                            if (nack_q) begin
                                st_q <= ST_IGNORE;
                            end else begin
                                st_q      <= ST_RDATA;
                                shreg_q   <= rd_load;
                                bit_cnt_q <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: open-drain drive for acknowledges and read data zeros.
    always_comb begin
        wr_byte = shreg_q;
        sda_oe  = (st_q == ST_ADDR_ACK) || (st_q == ST_WDATA_ACK) ||
                  (st_q == ST_RDATA && !shreg_q[BYTE_W-1]);
    end

    a_r1_ack_only_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR_ACK) |-> (shreg_q[7:1] == DEV_ADDR));
    a_r7_busy_refuses_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ADDR && scl_fall && bit_cnt_q == 4'd8 && busy_i) |=> (st_q == ST_IGNORE));
    a_r8_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st_q == ST_IDLE));
    a_r5_read_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RDATA && bit_cnt_q < 4'd3) |-> sda_oe);
endmodule

// File: rtl/cfgsw_store.sv
// Module: holds the configuration word and the programming interval timer.
// A write request is taken only with protection off and the top three byte
// bits clear; the word updates at once and the interval starts.
// Assumes: wr_req is a single-cycle pulse.
module cfgsw_store
    import cfgsw_pkg::*;
#(
    parameter int REG_W       = 5,
    parameter int PROG_CYCLES = 1500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              wp_i,
    output logic [REG_W-1:0]  word_o,
    output logic              busy_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [REG_W-1:0] word_q;
    logic [CW-1:0]    left_q;
    logic             upper_clear;
    logic             accept;

    // Purpose: acceptance rule for a received data byte.
    always_comb begin
        upper_clear = (wr_byte_i[BYTE_W-1:REG_W] == '0);
        accept      = wr_req_i && !wp_i && upper_clear;
    end

    // Purpose: commit the word and run the programming interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (accept) begin
            word_q <= wr_byte_i[REG_W-1:0];
            left_q <= CW'(PROG_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    always_comb begin
        word_o = word_q;
        busy_o = (left_q != '0);
    end

    a_r3_protect_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |=> $stable(word_q));
    a_r4_bad_byte_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wr_byte_i[BYTE_W-1:REG_W] != '0) |=> $stable(word_q));
    a_r7_accept_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !wp_i && wr_byte_i[BYTE_W-1:REG_W] == '0) |=> busy_o);
    a_r9_refusal_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !busy_o && (wp_i || wr_byte_i[BYTE_W-1:REG_W] != '0)) |=> !busy_o);
endmodule

// File: rtl/cfg_switch_target.sv
// Module: top of the serial configuration switch target. It wires the line
// synchroniser, the protocol engine and the word store together.
// Assumes: scl_i/sda_i are wire levels; sda_oe drives an open-drain pad.
module cfg_switch_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1001110,
    parameter int         REG_W       = 5,
    parameter int         PROG_CYCLES = 1500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             wp_i,
    output logic [REG_W-1:0] cfg_o
);
    import cfgsw_pkg::*;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_req, busy;
    logic [BYTE_W-1:0] wr_byte;
    logic [REG_W-1:0]  word;

    cfgsw_sync #(.LINES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_i     ({sda_i, scl_i}),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgsw_engine #(.DEV_ADDR(DEV_ADDR), .REG_W(REG_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy_i    (busy),
        .word_i    (word),
        .wr_req    (wr_req),
        .wr_byte   (wr_byte),
        .sda_oe    (sda_oe)
    );

    cfgsw_store #(.REG_W(REG_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req_i  (wr_req),
        .wr_byte_i (wr_byte),
        .wp_i      (wp_i),
        .word_o    (word),
        .busy_o    (busy)
    );

    always_comb cfg_o = word;

    a_r6_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sda_oe && cfg_o == '0));
endmodule

// File: tb/sim_cfg_switch_target.sv
module sim_cfg_switch_target;
    localparam int PROG = 400;
    localparam int H    = 10;
    localparam logic [6:0] ADDR = 7'b1001110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic [4:0] cfg;
    logic sda_line;
    int total = 0;
    int bad = 0;
    logic [4:0] exp_word = 5'd0;

    always #2 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    cfg_switch_target #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .wp_i(wp), .cfg_o(cfg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic accepts(input logic p, input logic [7:0] d);
        return !p && d[7:5] == 3'b000;
    endfunction

    task automatic bus_start();
        sda_drv = 1'b1; tick(H);
        scl = 1'b1; tick(H);
        sda_drv = 1'b0; tick(H);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(H);
        scl = 1'b1; tick(H);
        sda_drv = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; tick(H);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(2);
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; tick(H);
        scl = 1'b1; tick(H / 2);
        b = sda_line; tick(H / 2);
        scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(r);
        ack = !r;
    endtask

    task automatic do_write(input logic [7:0] d, output logic aa, output logic da);
        bus_start();
        send_byte({ADDR, 1'b0}, aa);
        da = 1'b0;
        if (aa) send_byte(d, da);
        bus_stop();
    endtask

    task automatic do_read(output logic aa, output logic [7:0] d);
        logic b;
        bus_start();
        send_byte({ADDR, 1'b1}, aa);
        d = 8'hxx;
        if (aa) begin
            for (int i = 7; i >= 0; i--) begin
                recv_bit(b);
                d[i] = b;
            end
            send_bit(1'b1);
        end
        bus_stop();
    endtask

    initial begin : watchdog
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        logic aa, da, b, acc;
        logic [7:0] d, rd;
        void'($urandom(32'd1234));
        tick(5);
        chk("R6 cfg after reset", int'(cfg), 0);
        chk("R6 sda_oe after reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(5);
        chk("R6 cfg out of reset", int'(cfg), 0);

        // R2 basic write and readback
        do_write(8'h15, aa, da);
        chk("R1 addr ack on write", int'(aa), 1);
        chk("R2 data ack", int'(da), 1);
        tick(4);
        chk("R2 cfg after write", int'(cfg), 5'h15);
        exp_word = 5'h15;

        // R7 address during programming interval is not acked
        do_read(aa, rd);
        chk("R7 addr nack while busy", int'(aa), 0);
        chk("R7 cfg unchanged", int'(cfg), 5'h15);
        tick(PROG + 100);
        do_read(aa, rd);
        chk("R7 addr ack after interval", int'(aa), 1);
        chk("R5 read data", int'(rd), 8'h15);

        // R1 wrong address: line stays released for the rest of the frame
        bus_start();
        send_byte({7'b1001111, 1'b1}, aa);
        chk("R1 wrong addr no ack", int'(aa), 0);
        for (int i = 0; i < 9; i++) begin
            recv_bit(b);
            chk("R1 released after mismatch", int'(b), 1);
        end
        bus_stop();

        // R4 malformed byte refused, R9 no interval
        do_write(8'hA3, aa, da);
        chk("R4 data ack on bad byte", int'(da), 1);
        chk("R4 cfg kept", int'(cfg), int'(exp_word));
        do_read(aa, rd);
        chk("R9 addr ack after bad byte", int'(aa), 1);
        chk("R5 read after bad byte", int'(rd), int'({3'b000, exp_word}));

        // R3 write protect, R9 no interval
        wp = 1'b1;
        do_write(8'h0A, aa, da);
        chk("R3 data ack while protected", int'(da), 1);
        chk("R3 cfg kept", int'(cfg), int'(exp_word));
        do_read(aa, rd);
        chk("R9 addr ack after protected write", int'(aa), 1);
        wp = 1'b0;

        // R8 STOP mid data byte
        bus_start();
        send_byte({ADDR, 1'b0}, aa);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        tick(4);
        chk("R8 cfg after stop mid byte", int'(cfg), int'(exp_word));

        // R8 repeated START mid data byte, then read
        bus_start();
        send_byte({ADDR, 1'b0}, aa);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        send_byte({ADDR, 1'b1}, aa);
        chk("R8 addr ack after repeated start", int'(aa), 1);
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            rd[i] = b;
        end
        send_bit(1'b1);
        bus_stop();
        chk("R8 read after repeated start", int'(rd), int'({3'b000, exp_word}));

        // Random mix
        for (int it = 0; it < 40; it++) begin
            if ($urandom % 2 == 0) begin
                d = 8'($urandom);
                if ($urandom % 4 != 0) d[7:5] = 3'b000;
                wp = ($urandom % 3 == 0);
                acc = accepts(wp, d);
                do_write(d, aa, da);
                chk("R1 random addr ack", int'(aa), 1);
                chk("R2 random data ack", int'(da), 1);
                if (acc) exp_word = d[4:0];
                tick(4);
                chk(acc ? "R2 random cfg" : "R3 R4 random cfg kept", int'(cfg), int'(exp_word));
                wp = 1'b0;
                tick(acc ? PROG + 100 : 20);
            end else begin
                do_read(aa, rd);
                chk("R1 random read ack", int'(aa), 1);
                chk("R5 random read data", int'(rd), int'({3'b000, exp_word}));
                tick(20);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule